// File: doc/BRIEF.md
# RTC Sleep Wakeup Timer

This block holds the time at which a sleeping board should be woken. Software writes a 32-bit wakeup time one byte at a time, or writes a 32-bit offset and then sets a command bit. The command bit loads the live RTC seconds count plus that offset into the wakeup time. While hardware sleep is enabled and the board reports that it has gone to sleep, the block compares the free-running RTC count with the wakeup time. When the count reaches the wakeup time, it raises a wake request and reports the timer's wake-cause code.

The byte write port is a valid/ready stream. A write transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` goes low for exactly one cycle after an add command is accepted, while the sum is being loaded. A producer that holds `wr_valid` with its address and data stable loses nothing. Readback is a plain combinational port: `rd_data` follows `rd_addr` and shows register state as it stands after the most recent edge.

Top module: `rtc_wake_timer`

## Requirements
- R1: The wakeup time is written as bytes at addresses 2, 3, 4 and 5, holding bits 7:0, 15:8, 23:16 and 31:24 respectively. Each byte takes effect at the edge that accepts the write and reads back at the same address.
- R2: The offset is written as bytes at addresses 6, 7, 8 and 9, holding bits 7:0, 15:8, 23:16 and 31:24 respectively. Each byte reads back at the same address.
- R3: A write to address 1 with bit 2 set starts an add. At the next edge, the wakeup time becomes the RTC count sampled at that edge plus the offset, modulo 2^32.
- R4: Address 1 reads back bit 0 as the sleep enable and bit 2 as the add-in-progress flag. Bit 2 is 1 only in the single cycle between the command edge and the load edge, and 0 afterwards. All other bits of address 1 read back as 0.
- R5: `wr_ready` is 1 at all times except the one cycle in which an add is in progress. A write offered in that cycle is held off and is accepted on the next edge.
- R6: The wake request rises one edge after an edge at which sleep is enabled, `asleep` is high and the RTC count is greater than or equal to the wakeup time.
- R7: Once raised, the wake request stays high while `asleep` and the enable remain high, even if the RTC count later falls below the wakeup time. It is cleared at the first edge where `asleep` or the enable is low.
- R8: `wake_cause` reads 6 while the wake request is high and 0 otherwise.
- R9: After reset, the wakeup time, the offset, the enable and the add flag are all 0, the wake request is low, and `wr_ready` is high.
- R10: Writes to any address other than 1 through 9 change nothing. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write offer |
| wr_ready | output | 1 | Write can be accepted |
| wr_addr | input | 5 | Byte register address of the write |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 5 | Byte register address to read |
| rd_data | output | 8 | Byte read, combinational |
| rtc_count | input | 32 | Free-running RTC seconds |
| asleep | input | 1 | Board has entered sleep |
| wake_req | output | 1 | Wake request |
| wake_cause | output | 4 | Wake-cause code |

## Verification
A corrupted wakeup or offset byte shows on `rd_data` in the cycle after the bad edge, and only at the address of that byte. It also shifts the cycle in which `wake_req` rises. A wrong add, such as a carry lost across a byte boundary or the RTC sampled on the wrong edge, shows when the wakeup time is read back right after the load edge. A stuck add flag shows on `wr_ready` and on bit 2 of address 1 one cycle later. Faults in the sticky or gating logic show on `wake_req` within one edge of `asleep`, the enable or the RTC count changing.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NBYTES     = 4;
  localparam int unsigned TIME_W     = BYTE_W * NBYTES;
  localparam int unsigned CTRL_ADDR  = 1;
  localparam int unsigned WAKE_BASE  = 2;
  localparam int unsigned OFF_BASE   = WAKE_BASE + NBYTES;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned ADD_BIT    = 2;
  localparam int unsigned CAUSE_W    = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_TIMER = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 4'd0;
endpackage

// File: rtl/rtc_wake_adder.sv
module rtc_wake_adder
  import rtc_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] rtc,
  input  logic [TIME_W-1:0] offset,
  output logic              busy,
  output logic              load,
  output logic [TIME_W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= start;
  end

  assign load = busy;
  assign sum  = rtc + offset;
endmodule

// File: rtl/rtc_wake_regs.sv
module rtc_wake_regs
  import rtc_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load,
  input  logic [TIME_W-1:0] load_value,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [TIME_W-1:0] wake_time,
  output logic [TIME_W-1:0] offset,
  output logic              sleep_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) sleep_en <= 1'b0;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) sleep_en <= wr_data[EN_BIT];
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wake_time[i*BYTE_W +: BYTE_W] <= '0;
      end else if (load) begin
        wake_time[i*BYTE_W +: BYTE_W] <= load_value[i*BYTE_W +: BYTE_W];
      end else if (wr_en && wr_addr == ADDR_W'(WAKE_BASE + i)) begin
        wake_time[i*BYTE_W +: BYTE_W] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        offset[i*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(OFF_BASE + i)) begin
        offset[i*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_data[EN_BIT]  = sleep_en;
      rd_data[ADD_BIT] = busy;
    end else begin
      for (int j = 0; j < NBYTES; j++) begin
        if (rd_addr == ADDR_W'(WAKE_BASE + j)) rd_data = wake_time[j*BYTE_W +: BYTE_W];
        if (rd_addr == ADDR_W'(OFF_BASE + j))  rd_data = offset[j*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/rtc_wake_cmp.sv
module rtc_wake_cmp
  import rtc_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asleep,
  input  logic              sleep_en,
  input  logic [TIME_W-1:0] rtc,
  input  logic [TIME_W-1:0] wake_time,
  output logic              wake
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 wake <= 1'b0;
    else if (!asleep || !sleep_en) wake <= 1'b0;
    else if (rtc >= wake_time)  wake <= 1'b1;
  end
endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer
  import rtc_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic [TIME_W-1:0]  rtc_count,
  input  logic               asleep,
  output logic               wake_req,
  output logic [CAUSE_W-1:0] wake_cause
);
  logic              wr_fire;
  logic              add_start;
  logic              pending_q;
  logic              add_load;
  logic [TIME_W-1:0] add_sum;
  logic [TIME_W-1:0] wake_time_q;
  logic [TIME_W-1:0] offset_q;
  logic              sleep_en_q;

  assign wr_ready  = !pending_q;
  assign wr_fire   = wr_valid && wr_ready;
  assign add_start = wr_fire && wr_addr == ADDR_W'(CTRL_ADDR) && wr_data[ADD_BIT];

  rtc_wake_adder u_adder (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (add_start),
    .rtc    (rtc_count),
    .offset (offset_q),
    .busy   (pending_q),
    .load   (add_load),
    .sum    (add_sum)
  );

  rtc_wake_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_fire),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .load       (add_load),
    .load_value (add_sum),
    .busy       (pending_q),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .wake_time  (wake_time_q),
    .offset     (offset_q),
    .sleep_en   (sleep_en_q)
  );

  rtc_wake_cmp u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .asleep    (asleep),
    .sleep_en  (sleep_en_q),
    .rtc       (rtc_count),
    .wake_time (wake_time_q),
    .wake      (wake_req)
  );

  assign wake_cause = wake_req ? CAUSE_TIMER : CAUSE_NONE;
endmodule

// File: rtl/rtc_wake_timer_chk.sv
module rtc_wake_timer_chk
  import rtc_wake_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [BYTE_W-1:0]  wr_data,
  input logic [TIME_W-1:0]  rtc_count,
  input logic               asleep,
  input logic               wake_req,
  input logic [CAUSE_W-1:0] wake_cause,
  input logic [TIME_W-1:0]  wake_time_q,
  input logic               sleep_en_q
);
  assert_add_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == ADDR_W'(CTRL_ADDR) && wr_data[ADD_BIT]) |=> !wr_ready);

  assert_stall_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> wr_ready);

  assert_rise_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(asleep && sleep_en_q && rtc_count >= wake_time_q));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && asleep && sleep_en_q) |=> wake_req);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep || !sleep_en_q) |=> !wake_req);

  assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> wake_cause == CAUSE_TIMER);
endmodule

bind rtc_wake_timer rtc_wake_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rtc_count   (rtc_count),
  .asleep      (asleep),
  .wake_req    (wake_req),
  .wake_cause  (wake_cause),
  .wake_time_q (wake_time_q),
  .sleep_en_q  (sleep_en_q)
);

// File: tb/rtc_wake_timer_bench.sv
module rtc_wake_timer_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [31:0] rtc_count = '0;
  logic        asleep = 1'b0;
  logic        wake_req;
  logic [3:0]  wake_cause;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_wake_timer u_rtc_wake_timer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rtc_count(rtc_count), .asleep(asleep), .wake_req(wake_req), .wake_cause(wake_cause)
  );

  // Behavioural model: a 32-entry byte image plus a few flags.
  byte unsigned img [32];
  bit m_pend, m_req;

  function automatic logic [31:0] img_word(int base);
    return {img[base+3], img[base+2], img[base+1], img[base]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (img[k]) img[k] = 0;
      m_pend = 0;
      m_req  = 0;
    end else begin
      logic [31:0] nw;
      bit nreq, fire;
      nreq = m_req;
      if (!asleep || img[1][0] == 0) nreq = 0;
      else if (rtc_count >= img_word(2)) nreq = 1;
      fire = wr_valid && !m_pend;
      if (m_pend) begin
        nw = rtc_count + img_word(6);
        for (int b = 0; b < 4; b++) img[2+b] = nw[8*b +: 8];
      end
      if (fire) begin
        if (wr_addr == 1) img[1] = {7'd0, wr_data[0]};
        else if (wr_addr >= 2 && wr_addr <= 9) img[wr_addr] = wr_data;
      end
      m_pend = fire && wr_addr == 1 && wr_data[2];
      m_req  = nreq;
    end
  end

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    if (a == 1) return {5'd0, m_pend, 1'b0, img[1][0]};
    if (a >= 2 && a <= 9) return img[a];
    return 8'd0;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(wake_req == m_req, "R6/R7 wake_req", wake_req, m_req);
      check(wake_cause == (m_req ? 4'd6 : 4'd0), "R8 wake_cause", wake_cause, m_req ? 6 : 0);
      check(wr_ready == !m_pend, "R5 wr_ready", wr_ready, !m_pend);
      check(rd_data == exp_rd(rd_addr), "R1/R2/R4/R10 rd_data", rd_data, exp_rd(rd_addr));
    end
  end

  task automatic put(logic [4:0] a, logic [7:0] d);
    @(negedge clk); #1;
    wr_valid = 1; wr_addr = a; wr_data = d;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic peek(logic [4:0] a, logic [7:0] exp, string tag);
    @(negedge clk); #1;
    rd_addr = a;
    #1;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R9 reset state
    check(wake_req == 0, "R9 wake_req", wake_req, 0);
    check(wr_ready == 1, "R9 wr_ready", wr_ready, 1);
    for (int a = 1; a < 10; a++) peek(a[4:0], 8'h00, "R9 reg zero");

    // R1 wakeup bytes, LSB at address 2
    put(2, 8'h44); put(3, 8'h33); put(4, 8'h22); put(5, 8'h00);
    peek(2, 8'h44, "R1 byte0"); peek(5, 8'h00, "R1 byte3");
    // R2 offset bytes
    put(6, 8'h20); put(7, 8'h01); put(8, 8'h00); put(9, 8'h00);
    peek(6, 8'h20, "R2 byte0"); peek(7, 8'h01, "R2 byte1");

    // R6 below target: no wake; then reach target
    rtc_count = 32'h0022_3340; asleep = 1;
    put(1, 8'h01);
    cyc(3);
    check(wake_req == 0, "R6 below target", wake_req, 0);
    rtc_count = 32'h0022_3344;
    cyc(2);
    check(wake_req == 1, "R6 at target", wake_req, 1);
    check(wake_cause == 6, "R8 cause", wake_cause, 6);
    // R7 sticky when RTC drops
    rtc_count = 32'h0000_0001;
    cyc(3);
    check(wake_req == 1, "R7 sticky", wake_req, 1);
    asleep = 0;
    cyc(2);
    check(wake_req == 0, "R7 leave sleep", wake_req, 0);

    // R6 enable off: no wake
    put(1, 8'h00);
    rtc_count = 32'hFFFF_FFFF; asleep = 1;
    cyc(3);
    check(wake_req == 0, "R6 disabled", wake_req, 0);
    asleep = 0;

    // R3 add with wrap, R4 flag, R5 stall of a back-to-back write
    rtc_count = 32'hFFFF_FF00;
    @(negedge clk); #1;
    wr_valid = 1; wr_addr = 1; wr_data = 8'h05;
    @(negedge clk); #1;
    wr_addr = 6; wr_data = 8'h77; rd_addr = 1; #1;
    check(wr_ready == 0, "R5 stall", wr_ready, 0);
    check(rd_data == 8'h05, "R4 flag set", rd_data, 8'h05);
    @(negedge clk); #1;
    check(rd_data == 8'h01, "R4 flag clear", rd_data, 8'h01);
    @(negedge clk); #1;
    wr_valid = 0;
    peek(2, 8'h20, "R3 sum byte0"); peek(3, 8'h00, "R3 sum byte1");
    peek(4, 8'h00, "R3 sum byte2"); peek(5, 8'h00, "R3 sum byte3");
    peek(6, 8'h77, "R5 held write");

    // R10 unmapped addresses
    put(0, 8'hFF); put(10, 8'hFF); put(31, 8'hFF);
    peek(0, 8'h00, "R10 addr0"); peek(10, 8'h00, "R10 addr10"); peek(31, 8'h00, "R10 addr31");
    peek(1, 8'h01, "R10 ctrl intact"); peek(9, 8'h00, "R10 offset intact");

    cyc(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule